// File: doc/BRIEF.md
# Lockable interrupt translation cache

This block turns a message-signalled interrupt, named by a device number and an event number, into the number of the processor that must take it. The translation is resolved through three small two-way set-associative caches in a chain. The first gives the base address of the device's event table. The second, keyed by device and event together, gives a collection number. The third turns the collection into a processor number. When all three stages hit, the result is ready three cycles after the request is taken.

A miss at any stage fetches the missing entry over a simple read-request port. The block then fills the cache and carries on with the next stage. The device table has two levels, so a device miss costs two reads. Only one read is in flight at a time, and new requests are held off while a walk is running. Software can pin a translation by sending the same request with the lock flag set. The entries it touches in all three caches are then protected from replacement and from invalidation, so that translation never misses again.

Top module: `itc_xlate_top`

## Requirements
- R1: For device d and event e the block returns the processor number held in the collection table for the collection that the event table gives. With every stage hitting, `rsp_valid` rises after the third rising edge that follows the one accepting the request, and it stays high for one cycle.
- R2: On a cold lookup, the reads go to the following addresses, in this order. The first is `DEV_TBL_BASE + d[DEV_W-1:SUB_W]`, which returns a subtable base B. The second is `B + d[SUB_W-1:0]`, which returns the event table base T. The third is `T + e`, and the low `COL_W` bits of its word are the collection c. The fourth is `COL_TBL_BASE + c`, and the low `CORE_W` bits of its word are the processor. A fully cold lookup makes exactly four reads.
- R3: Repeating a translation that is resident in all three caches issues no memory read.
- R4: A word of zero returned by any read ends the walk with `rsp_err`=1 and `rsp_core`=0. Nothing is cached for the failing stage, so a repeat makes the same reads again.
- R5: A request with `req_lock`=1 performs the translation and sets the lock bit on the matching way in all three caches. `lock_done` pulses together with `rsp_valid` when no error occurs. A request without the lock flag never pulses `lock_done`.
- R6: A locked translation makes no memory read, whatever other traffic has used its sets and across `inv_all`.
- R7: `inv_all` drops every unlocked entry of all three caches in one cycle, so the next lookup of an unlocked translation misses again.
- R8: A fill into a set whose two ways are both locked is not stored. The translation still returns the correct result, and a repeat makes the same reads again.
- R9: At most one read is outstanding. `mem_req_valid` with a stable `mem_req_addr` is held until `mem_req_ready`. `req_ready` is high only while idle, including during reset.
- R10: Replacement among unlocked valid ways evicts the way that was least recently hit or filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Drop every unlocked entry in all caches |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_dev | input | DEV_W | Device number |
| req_evt | input | EVT_W | Event number |
| req_lock | input | 1 | Pin the translation once resolved |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | A table entry read back as zero |
| rsp_core | output | CORE_W | Target processor number |
| lock_done | output | 1 | Lock request completed |
| mem_req_valid | output | 1 | Read request to table memory |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | ADDR_W | Read word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | ADDR_W | Read data word |

## Verification
Every device and event pair in the default configuration is translated and compared with a result the bench computes from its arithmetic table contents. This sweep separates a wrong table walk from a wrong cache hit, and one device whose second-level entry is zero exercises the error path. Short sequences within one set count reads per request. A same-set sequence of hit, hit and new fill tells true least-recently-used replacement from a fixed victim. Conflicting traffic around a pinned pair shows whether locks survive eviction and invalidation. Two pinned pairs that fill every way of their sets show that a further fill is dropped rather than evicting a locked way.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_EVT, ST_COL, ST_WAIT} xl_state_e;
  typedef enum logic [1:0] {FT_L1, FT_L2, FT_EVT, FT_COL} fetch_e;
endpackage

// File: rtl/itc_victim_pick.sv
module itc_victim_pick (
  input  logic [1:0] vld,
  input  logic [1:0] lck,
  input  logic       lru,
  output logic       way,
  output logic       ok
);
  always_comb begin
    ok  = 1'b1;
    way = 1'b0;
    if (!vld[0])      way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else if (&lck)    ok  = 1'b0;
    else if (lck[0])  way = 1'b1;
    else if (lck[1])  way = 1'b0;
    else              way = lru;
  end
endmodule

// File: rtl/itc_set_cache.sv
module itc_set_cache #(
  parameter int KEY_W    = 4,
  parameter int DATA_W   = 16,
  parameter int SET_BITS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic [KEY_W-1:0]  key,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              upd_en,
  input  logic              upd_lock,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_lock
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = KEY_W - SET_BITS;

  logic [TAG_W-1:0]  tag_q  [SETS][2];
  logic [DATA_W-1:0] data_q [SETS][2];
  logic [1:0]        vld_q  [SETS];
  logic [1:0]        lck_q  [SETS];
  logic              lru_q  [SETS];

  logic [SET_BITS-1:0] idx;
  logic [TAG_W-1:0]    tag;
  logic [1:0]          way_hit;
  logic                hit_way, vic_way, vic_ok;

  assign idx = key[SET_BITS-1:0];
  assign tag = key[KEY_W-1:SET_BITS];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_hit[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
  end

  assign hit      = |way_hit;
  assign hit_way  = way_hit[1];
  assign hit_data = data_q[idx][hit_way];

  itc_victim_pick u_pick (
    .vld (vld_q[idx]),
    .lck (lck_q[idx]),
    .lru (lru_q[idx]),
    .way (vic_way),
    .ok  (vic_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lck_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else begin
      if (inv_all)
        for (int s = 0; s < SETS; s++) vld_q[s] <= vld_q[s] & lck_q[s];
      if (upd_en && hit) begin
        lru_q[idx] <= ~hit_way;
        if (upd_lock) lck_q[idx][hit_way] <= 1'b1;
      end
      if (fill_en && vic_ok) begin
        vld_q[idx][vic_way]  <= 1'b1;
        lck_q[idx][vic_way]  <= fill_lock;
        tag_q[idx][vic_way]  <= tag;
        data_q[idx][vic_way] <= fill_data;
        lru_q[idx]           <= ~vic_way;
      end
    end
  end
endmodule

// File: rtl/itc_xlate_top.sv
module itc_xlate_top import itc_pkg::*; #(
  parameter int DEV_W    = 4,
  parameter int EVT_W    = 3,
  parameter int COL_W    = 3,
  parameter int CORE_W   = 3,
  parameter int ADDR_W   = 16,
  parameter int SUB_W    = 2,
  parameter int SET_BITS = 1,
  parameter logic [ADDR_W-1:0] DEV_TBL_BASE = 16'h0100,
  parameter logic [ADDR_W-1:0] COL_TBL_BASE = 16'h0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [EVT_W-1:0]  req_evt,
  input  logic              req_lock,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [CORE_W-1:0] rsp_core,
  output logic              lock_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int PAIR_W = DEV_W + EVT_W;

  xl_state_e         state_q;
  fetch_e            fetch_q;
  logic [DEV_W-1:0]  dev_q;
  logic [EVT_W-1:0]  evt_q;
  logic              lock_q;
  logic [ADDR_W-1:0] itt_q;
  logic [COL_W-1:0]  col_q;

  logic              dev_hit, evt_hit, col_hit;
  logic [ADDR_W-1:0] dev_data;
  logic [COL_W-1:0]  evt_data;
  logic [CORE_W-1:0] col_data;
  logic              rsp_take, rsp_zero;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_take  = (state_q == ST_WAIT) && mem_rsp_valid;
  assign rsp_zero  = (mem_rsp_data == '0);

  itc_set_cache #(.KEY_W(DEV_W), .DATA_W(ADDR_W), .SET_BITS(SET_BITS)) u_dev (
    .clk, .rst, .inv_all, .key(dev_q), .hit(dev_hit), .hit_data(dev_data),
    .upd_en(state_q == ST_DEV), .upd_lock(lock_q),
    .fill_en(rsp_take && !rsp_zero && fetch_q == FT_L2),
    .fill_data(mem_rsp_data), .fill_lock(lock_q));

  itc_set_cache #(.KEY_W(PAIR_W), .DATA_W(COL_W), .SET_BITS(SET_BITS)) u_evt (
    .clk, .rst, .inv_all, .key({dev_q, evt_q}), .hit(evt_hit), .hit_data(evt_data),
    .upd_en(state_q == ST_EVT), .upd_lock(lock_q),
    .fill_en(rsp_take && !rsp_zero && fetch_q == FT_EVT),
    .fill_data(mem_rsp_data[COL_W-1:0]), .fill_lock(lock_q));

  itc_set_cache #(.KEY_W(COL_W), .DATA_W(CORE_W), .SET_BITS(SET_BITS)) u_col (
    .clk, .rst, .inv_all, .key(col_q), .hit(col_hit), .hit_data(col_data),
    .upd_en(state_q == ST_COL), .upd_lock(lock_q),
    .fill_en(rsp_take && !rsp_zero && fetch_q == FT_COL),
    .fill_data(mem_rsp_data[CORE_W-1:0]), .fill_lock(lock_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      fetch_q       <= FT_L1;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_core      <= '0;
      lock_done     <= 1'b0;
      dev_q         <= '0;
      evt_q         <= '0;
      lock_q        <= 1'b0;
      itt_q         <= '0;
      col_q         <= '0;
    end else begin
      rsp_valid <= 1'b0;
      lock_done <= 1'b0;
      if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          dev_q   <= req_dev;
          evt_q   <= req_evt;
          lock_q  <= req_lock;
          state_q <= ST_DEV;
        end
        ST_DEV: if (dev_hit) begin
          itt_q   <= dev_data;
          state_q <= ST_EVT;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= DEV_TBL_BASE + ADDR_W'(dev_q[DEV_W-1:SUB_W]);
          fetch_q       <= FT_L1;
          state_q       <= ST_WAIT;
        end
        ST_EVT: if (evt_hit) begin
          col_q   <= evt_data;
          state_q <= ST_COL;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= itt_q + ADDR_W'(evt_q);
          fetch_q       <= FT_EVT;
          state_q       <= ST_WAIT;
        end
        ST_COL: if (col_hit) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_core  <= col_data;
          lock_done <= lock_q;
          state_q   <= ST_IDLE;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= COL_TBL_BASE + ADDR_W'(col_q);
          fetch_q       <= FT_COL;
          state_q       <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          if (rsp_zero) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_core  <= '0;
            state_q   <= ST_IDLE;
          end else begin
            case (fetch_q)
              FT_L1: begin
                mem_req_valid <= 1'b1;
                mem_req_addr  <= mem_rsp_data + ADDR_W'(dev_q[SUB_W-1:0]);
                fetch_q       <= FT_L2;
              end
              FT_L2: begin
                itt_q   <= mem_rsp_data;
                state_q <= ST_EVT;
              end
              FT_EVT: begin
                col_q   <= mem_rsp_data[COL_W-1:0];
                state_q <= ST_COL;
              end
              default: begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b0;
                rsp_core  <= mem_rsp_data[CORE_W-1:0];
                lock_done <= lock_q;
                state_q   <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itc_xlate_checker.sv
module itc_xlate_checker #(
  parameter int CORE_W = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [CORE_W-1:0] rsp_core,
  input logic              lock_done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  logic outst_q;

  always_ff @(posedge clk) begin
    if (rst) outst_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
    else if (mem_rsp_valid) outst_q <= 1'b0;
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !outst_q);

  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || outst_q) |-> !req_ready);

  assert_lock_done_R5: assert property (@(posedge clk) disable iff (rst)
    lock_done |-> rsp_valid && !rsp_err);

  assert_err_core_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_core == '0);

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind itc_xlate_top itc_xlate_checker #(.CORE_W(CORE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_core(rsp_core), .lock_done(lock_done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid));

// File: tb/itc_xlate_top_tb_top.sv
module itc_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_dev = '0;
  logic [2:0]  req_evt = '0;
  logic        req_lock = 1'b0;
  logic        rsp_valid, rsp_err, lock_done;
  logic [2:0]  rsp_core;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;

  int checks = 0, fails = 0;
  int nrd = 0, lat = 0, dly = 0, tog = 0;
  logic [15:0] pend_addr = '0;
  int g_core, g_err, g_done;

  always #10 clk = ~clk;

  itc_xlate_top dut_i (
    .clk, .rst, .inv_all, .req_valid, .req_ready, .req_dev, .req_evt, .req_lock,
    .rsp_valid, .rsp_err, .rsp_core, .lock_done, .mem_req_valid, .mem_req_ready,
    .mem_req_addr, .mem_rsp_valid, .mem_rsp_data);

  function automatic logic [15:0] model(input logic [15:0] a);
    int ai = int'(a);
    int dv, ev;
    if (ai >= 'h100 && ai < 'h104) return 16'(('h1000 + (ai - 'h100) * 16));
    if (ai >= 'h1000 && ai < 'h1040) begin
      dv = ((ai - 'h1000) >> 4) * 4 + (ai & 3);
      if (dv == 13) return 16'h0000;
      return 16'(('h2000 + dv * 16));
    end
    if (ai >= 'h2000 && ai < 'h2100) begin
      dv = (ai - 'h2000) >> 4;
      ev = ai & 15;
      return 16'(('h8000 | ((dv + ev) & 7)));
    end
    if (ai >= 'h200 && ai < 'h208) return 16'(('h8000 | ((((ai - 'h200) * 3) + 1) & 7)));
    return 16'h0000;
  endfunction

  function automatic int exp_core(input int d, input int e);
    return ((((d + e) & 7) * 3) + 1) & 7;
  endfunction

  always @(negedge clk) begin
    tog = tog + 1;
    mem_rsp_valid = 1'b0;
    if (mem_req_valid && (tog % 3 != 0)) begin
      pend_addr = mem_req_addr;
      dly = 2;
      nrd = nrd + 1;
      mem_req_ready = 1'b1;
    end else begin
      mem_req_ready = (tog % 3 != 0);
      if (dly == 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = model(pend_addr);
        dly = 0;
      end else if (dly > 1) dly = dly - 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int d, input int e, input bit lk);
    @(negedge clk);
    req_dev = 4'(d); req_evt = 3'(e); req_lock = lk; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    nrd = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!rsp_valid && lat < 400);
    g_core = int'(rsp_core); g_err = int'(rsp_err); g_done = int'(lock_done);
    if (lat >= 400) begin
      checks++; fails++;
      $display("FAIL R1 response timeout actual=%0d expected=<400", lat);
    end
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ready during reset", int'(req_ready), 1);
    chk("R1 rsp_valid low in reset", int'(rsp_valid), 0);
    chk("R9 no read in reset", int'(mem_req_valid), 0);
    @(negedge clk); rst = 1'b0;

    // R2 cold walk, R3 and R1 hit timing, R10 replacement order
    run(0, 1, 0);
    chk("R2 cold reads", nrd, 4);
    chk("R2 cold core", g_core, exp_core(0, 1));
    run(2, 1, 0);
    run(0, 1, 0);
    chk("R3 hit no reads", nrd, 0);
    chk("R1 hit latency", lat, 3);
    chk("R5 no lock_done without lock", g_done, 0);
    run(4, 1, 0);
    run(0, 1, 0);
    chk("R10 recently used kept", nrd, 0);
    run(2, 1, 0);
    chk("R10 least recent evicted", nrd, 4);

    // R1 and R4: full sweep
    for (int d = 0; d < 16; d++) begin
      for (int e = 0; e < 8; e++) begin
        run(d, e, 0);
        if (d == 13) begin
          chk("R4 zero entry err", g_err, 1);
          chk("R4 err core", g_core, 0);
        end else begin
          chk("R1 sweep core", g_core, exp_core(d, e));
          chk("R1 sweep no err", g_err, 0);
        end
      end
    end
    run(13, 0, 0);
    run(13, 0, 0);
    chk("R4 error not cached", nrd, 2);

    // R5 lock, R6 survives conflicting traffic
    run(5, 2, 1);
    chk("R5 lock_done", g_done, 1);
    chk("R5 lock core", g_core, exp_core(5, 2));
    run(7, 0, 0); run(9, 2, 0); run(11, 4, 0); run(15, 6, 0); run(1, 2, 0); run(3, 0, 0);
    run(5, 2, 0);
    chk("R6 locked after thrash reads", nrd, 0);
    chk("R6 locked latency", lat, 3);

    // R7 invalidate keeps locks
    run(0, 1, 0);
    run(0, 1, 0);
    chk("R3 warm before inv", nrd, 0);
    pulse_inv();
    run(0, 1, 0);
    chk("R7 unlocked dropped", nrd, 4);
    chk("R7 core after inv", g_core, exp_core(0, 1));
    run(5, 2, 0);
    chk("R6 locked after inv", nrd, 0);

    // R8 both ways locked
    run(1, 0, 1);
    chk("R5 second lock_done", g_done, 1);
    run(3, 0, 0);
    run(3, 0, 0);
    chk("R8 full-locked set not cached", nrd, 4);
    chk("R8 core correct", g_core, exp_core(3, 0));
    run(1, 0, 0);
    chk("R6 second pinned pair", nrd, 0);
    run(5, 2, 0);
    chk("R6 first pinned pair", nrd, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule